// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Scheduling

This block is a clocked sequencer for an asynchronous DRAM whose row and column addresses share one bus. It takes burst requests from a host and converts each into an activation followed by a page-mode burst. During the burst, row strobe stays low and every column beat gets its own column-strobe pulse. Then it precharges. Every timing minimum is a parameter counted in clock cycles. With the defaults and a 10 ns clock, the beat cadence is 5-2-2-2.

A free-running interval timer raises a refresh demand. That demand beats any new host request, but it never cuts into a burst already in flight. Refresh runs in one of two styles, chosen by an input. In the row-only style, the controller drives the next row from its own wrapping counter and pulses row strobe with no column strobe. In the strobe-order style, column strobe goes low before row strobe, and the memory picks the row from its own internal counter.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, and after it is released with nothing pending, both strobes and write enable are high, the data driver is off, `rd_valid` is low and `req_ready` is high.
- R2: `req_addr` holds the row in its upper ROW_W bits and the column in its lower COL_W bits. An accepted request drops `dram_ras_n` in the next cycle, with the row on `dram_addr`. The first fall of `dram_cas_n` comes exactly T_RCD cycles after that.
- R3: A burst is BURST_LEN beats. Each beat holds `dram_cas_n` low for T_CAS cycles, with the column on `dram_addr`. Beats are separated by T_CP high cycles and row strobe stays low throughout. Beat b uses column (start + b) modulo 2^COL_W. The defaults give data in cycles 5, 7, 9 and 11 after the row opens.
- R4: `dram_ras_n` stays low for at least T_RAS cycles. After it rises, it stays high for at least T_RP cycles. Each burst or refresh ends with exactly T_RP precharge cycles.
- R5: On a read, `rd_valid` pulses for one cycle after the last low cycle of each beat. `rd_data` carries `dram_dq_in` as sampled in that last low cycle.
- R6: On a write, `dram_we_n` is low for the whole row-open period. `dram_dq_oe` is high exactly in the column-strobe low cycles, and beat b drives `req_wdata[b*DATA_W +: DATA_W]`.
- R7: A refresh demand rises every REF_INTERVAL cycles, counted from reset. `req_ready` is high only when the controller is idle and no refresh is pending.
- R8: When idle with a refresh pending, the controller starts the refresh even if a host request is waiting. A refresh that falls due during a burst waits for the burst and its precharge to finish.
- R9: With `ref_mode`=0, refresh holds `dram_ras_n` low for T_RAS cycles, keeps `dram_cas_n` high and drives the internal row counter on `dram_addr`. The counter then advances, wrapping from REF_ROWS-1 to 0.
- R10: With `ref_mode`=1, `dram_cas_n` goes low one cycle before `dram_ras_n` falls. Both stay low for T_RAS cycles and rise together. The internal row counter does not advance.
- R11: Every refresh is issued before the following interval expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host burst request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ROW_W+COL_W | {row, start column} |
| req_wdata | input | BURST_LEN*DATA_W | Write data, beat b in lane b |
| rd_valid | output | 1 | One-cycle pulse per read beat |
| rd_data | output | DATA_W | Read data of the beat |
| ref_mode | input | 1 | 0 = row-only refresh, 1 = strobe-order refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to memory |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | DATA_W | Read data from memory |

## Verification
The controller runs against a memory stub under a mixed stream of read and write bursts. Start columns are spread freely, so some bursts wrap within the row. Some reads return to locations that were just written, which separates wrong column sequencing from wrong data lanes. Idle gaps alternate with back-to-back requests. This lets refresh fall due both while the controller is idle and in the middle of a burst, which exposes priority and precharge errors. The run passes through row-only, then strobe-order, then row-only refresh again. Row-counter wrap and the rule that strobe-order refresh leaves the counter alone both show up in the row addresses driven afterwards.

// File: rtl/dpc_pkg.sv
// Shared types and helpers for the page-mode DRAM controller.
package dpc_pkg;

    // Sequencer states; the strobe pins are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, precharge complete
        ST_ACT,    // row strobe low, waiting out row-to-column delay
        ST_CLO,    // column strobe low for one beat
        ST_CHI,    // column strobe high between beats
        ST_HOLD,   // row still open after last beat until minimum width met
        ST_PRE,    // row strobe high, precharge in progress
        ST_CBR,    // column strobe low ahead of row strobe (refresh setup)
        ST_REF     // row strobe low for a refresh
    } dpc_state_e;

    function automatic int dpc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dpc_refresh.sv
// Refresh scheduler: interval timer, pending flag and row counter.
// Assumes REF_INTERVAL >= 2 and that the sequencer grants a pending
// refresh well within one interval.
module dpc_refresh #(
    parameter int REF_INTERVAL = 780,
    parameter int ROW_W        = 4,
    parameter int REF_ROWS     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_start,
    input  logic             ref_row_adv,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TW = $clog2(REF_INTERVAL);

    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = (tcnt == TW'(REF_INTERVAL - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    tcnt <= '0;
        else if (tick) tcnt <= '0;
        else           tcnt <= tcnt + 1'b1;
    end

    // Demand flag: set by the timer, cleared when the sequencer grants it.
    always_ff @(posedge clk) begin
        if (!rst_n)         ref_pending <= 1'b0;
        else if (tick)      ref_pending <= 1'b1;
        else if (ref_start) ref_pending <= 1'b0;
    end

    // Row counter; wrap style picked by whether the row count fills the width.
    generate
        if (REF_ROWS == (1 << ROW_W)) begin : g_wrap_nat
            // Natural binary wrap.
            always_ff @(posedge clk) begin
                if (!rst_n)           ref_row <= '0;
                else if (ref_row_adv) ref_row <= ref_row + 1'b1;
            end
        end else begin : g_wrap_cmp
            // Explicit wrap at the last row.
            always_ff @(posedge clk) begin
                if (!rst_n) ref_row <= '0;
                else if (ref_row_adv)
                    ref_row <= (ref_row == ROW_W'(REF_ROWS - 1)) ? '0 : ref_row + 1'b1;
            end
        end
    endgenerate

    // R11: a pending refresh is granted before the next interval expires.
    assert_refresh_deadline_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ref_pending) |-> ref_start);

endmodule

// File: rtl/dpc_seq.sv
// Strobe sequencer: runs activation, page-mode beats, row hold, precharge
// and both refresh styles. Assumes T_RCD, T_CAS, T_CP, T_RAS, T_RP >= 1
// and BURST_LEN >= 2. Pins are decoded from registered state.
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 4,
    parameter int T_CAS     = 1,
    parameter int T_CP      = 1,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ROW_W+COL_W-1:0]        req_addr,
    input  logic [BURST_LEN*DATA_W-1:0]   req_wdata,
    output logic                          req_ready,
    input  logic                          ref_pending,
    input  logic                          ref_mode,
    input  logic [ROW_W-1:0]              ref_row,
    output logic                          ref_start,
    output logic                          ref_row_adv,
    output logic                          cap_en,
    output logic                          ras_n,
    output logic                          cas_n,
    output logic                          we_n,
    output logic [dpc_max(ROW_W,COL_W)-1:0] addr,
    output logic [DATA_W-1:0]             dq_out,
    output logic                          dq_oe
);
    localparam int AW   = dpc_max(ROW_W, COL_W);
    localparam int CMAX = dpc_max(dpc_max(T_RCD, T_CAS), dpc_max(T_CP, T_RP));
    localparam int CW   = $clog2(CMAX + 1);
    localparam int BW   = $clog2(BURST_LEN);
    localparam int RMAX = dpc_max(T_RAS, T_RCD);
    localparam int RCW  = $clog2(RMAX + 1);
    localparam int HCW  = $clog2(T_RP + 1);

    dpc_state_e                  st;
    logic [CW-1:0]               cnt;
    logic [BW-1:0]               beat;
    logic [ROW_W-1:0]            row_q;
    logic [COL_W-1:0]            col_q;
    logic [COL_W-1:0]            col_cur;
    logic                        wr_q;
    logic                        cbr_q;
    logic [BURST_LEN*DATA_W-1:0] wdat_q;
    logic [RCW-1:0]              ras_cnt;
    logic [HCW-1:0]              hi_cnt;
    logic                        ras_low;
    logic                        ras_ok;
    logic                        last_beat;

    assign ras_low   = (st == ST_ACT) || (st == ST_CLO) || (st == ST_CHI) ||
                       (st == ST_HOLD) || (st == ST_REF);
    assign ras_ok    = (int'(ras_cnt) + 1) >= T_RAS;
    assign last_beat = (beat == BW'(BURST_LEN - 1));
    assign col_cur   = col_q + COL_W'(beat);

    // Handshake and refresh strobes toward the host and the scheduler.
    assign req_ready   = (st == ST_IDLE) && !ref_pending;
    assign ref_start   = (st == ST_IDLE) && ref_pending;
    assign ref_row_adv = (st == ST_REF) && ras_ok && !cbr_q;
    assign cap_en      = (st == ST_CLO) && (cnt == '0) && !wr_q;

    // Pin decode from the current state.
    always_comb begin
        ras_n  = !ras_low;
        cas_n  = !((st == ST_CLO) || (st == ST_CBR) || ((st == ST_REF) && cbr_q));
        we_n   = !(wr_q && ras_low && (st != ST_REF));
        dq_oe  = wr_q && (st == ST_CLO);
        dq_out = wdat_q[int'(beat)*DATA_W +: DATA_W];
        addr   = '0;
        case (st)
            ST_ACT:         addr = AW'(row_q);
            ST_CLO, ST_CHI: addr = AW'(col_cur);
            ST_REF:         addr = cbr_q ? '0 : AW'(ref_row);
            default:        addr = '0;
        endcase
    end

    // Main state machine with a shared down-counter for fixed phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            beat   <= '0;
            row_q  <= '0;
            col_q  <= '0;
            wr_q   <= 1'b0;
            cbr_q  <= 1'b0;
            wdat_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ref_pending) begin
                        cbr_q <= ref_mode;
                        wr_q  <= 1'b0;
                        st    <= ref_mode ? ST_CBR : ST_REF;
                    end else if (req_valid) begin
                        row_q  <= req_addr[COL_W +: ROW_W];
                        col_q  <= req_addr[COL_W-1:0];
                        wr_q   <= req_write;
                        wdat_q <= req_wdata;
                        cbr_q  <= 1'b0;
                        beat   <= '0;
                        cnt    <= CW'(T_RCD - 1);
                        st     <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    if (cnt == '0) begin
                        cnt <= CW'(T_CAS - 1);
                        st  <= ST_CLO;
                    end else cnt <= cnt - 1'b1;
                end
                ST_CLO: begin
                    if (cnt == '0) begin
                        if (last_beat) st <= ST_HOLD;
                        else begin
                            beat <= beat + 1'b1;
                            cnt  <= CW'(T_CP - 1);
                            st   <= ST_CHI;
                        end
                    end else cnt <= cnt - 1'b1;
                end
                ST_CHI: begin
                    if (cnt == '0) begin
                        cnt <= CW'(T_CAS - 1);
                        st  <= ST_CLO;
                    end else cnt <= cnt - 1'b1;
                end
                ST_HOLD, ST_REF: begin
                    if (ras_ok) begin
                        cnt  <= CW'(T_RP - 1);
                        wr_q <= 1'b0;
                        st   <= ST_PRE;
                    end
                end
                ST_CBR: st <= ST_REF;
                ST_PRE: begin
                    if (cnt == '0) begin
                        cbr_q <= 1'b0;
                        st    <= ST_IDLE;
                    end else cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Cycles row strobe has been low before the current one (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                       ras_cnt <= '0;
        else if (!ras_low)                ras_cnt <= '0;
        else if (int'(ras_cnt) < RMAX)    ras_cnt <= ras_cnt + 1'b1;
    end

    // Cycles row strobe has been high before the current one (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                       hi_cnt <= HCW'(T_RP);
        else if (ras_low)                 hi_cnt <= '0;
        else if (int'(hi_cnt) < T_RP)     hi_cnt <= hi_cnt + 1'b1;
    end

    // R2: column strobe may not fall inside an open row before T_RCD.
    assert_rcd_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> (int'(ras_cnt) >= T_RCD));

    // R4: row strobe low width.
    assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ((int'($past(ras_cnt)) + 1) >= T_RAS));

    // R4: precharge width before the next activation.
    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (int'(hi_cnt) >= T_RP));

    // R6: data is driven only inside a write column pulse.
    assert_drive_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!cas_n && !we_n && !ras_n));

    // R10: column strobe alone low is always followed by row strobe falling.
    assert_cbr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |=> (!ras_n && !cas_n));

endmodule

// File: rtl/dpc_rdpath.sv
// Read capture: registers memory data at the end of each read beat and
// flags it for one cycle. Assumes beats are at least two cycles apart.
module dpc_rdpath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // Capture register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= dq_in;
        end
    end

    // R5: each read beat yields a single-cycle valid.
    assert_rdv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/dram_page_ctrl.sv
// Top of the page-mode DRAM controller: connects the refresh scheduler,
// the strobe sequencer and the read capture path. Host bursts are
// BURST_LEN beats with sequential columns inside one row.
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DATA_W       = 8,
    parameter int BURST_LEN    = 4,
    parameter int T_RCD        = 4,
    parameter int T_CAS        = 1,
    parameter int T_CP         = 1,
    parameter int T_RAS        = 5,
    parameter int T_RP         = 3,
    parameter int REF_INTERVAL = 780,
    parameter int REF_ROWS     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [ROW_W+COL_W-1:0]          req_addr,
    input  logic [BURST_LEN*DATA_W-1:0]     req_wdata,
    output logic                            rd_valid,
    output logic [DATA_W-1:0]               rd_data,
    input  logic                            ref_mode,
    output logic                            dram_ras_n,
    output logic                            dram_cas_n,
    output logic                            dram_we_n,
    output logic [dpc_max(ROW_W,COL_W)-1:0] dram_addr,
    output logic [DATA_W-1:0]               dram_dq_out,
    output logic                            dram_dq_oe,
    input  logic [DATA_W-1:0]               dram_dq_in
);
    logic             ref_pending;
    logic             ref_start;
    logic             ref_row_adv;
    logic [ROW_W-1:0] ref_row;
    logic             cap_en;

    dpc_refresh #(
        .REF_INTERVAL (REF_INTERVAL),
        .ROW_W        (ROW_W),
        .REF_ROWS     (REF_ROWS)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_start   (ref_start),
        .ref_row_adv (ref_row_adv),
        .ref_pending (ref_pending),
        .ref_row     (ref_row)
    );

    dpc_seq #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DATA_W    (DATA_W),
        .BURST_LEN (BURST_LEN),
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_CP      (T_CP),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .ref_pending (ref_pending),
        .ref_mode    (ref_mode),
        .ref_row     (ref_row),
        .ref_start   (ref_start),
        .ref_row_adv (ref_row_adv),
        .cap_en      (cap_en),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .addr        (dram_addr),
        .dq_out      (dram_dq_out),
        .dq_oe       (dram_dq_oe)
    );

    dpc_rdpath #(
        .DATA_W (DATA_W)
    ) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .dq_in    (dram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/dram_page_ctrl_tb_top.sv
// Bench: memory stub plus a behavioural per-cycle pin model, compared
// with the controller on every clock.
module dram_page_ctrl_tb_top;
    localparam int CLK_PERIOD   = 10;
    localparam int ROW_W        = 4;
    localparam int COL_W        = 4;
    localparam int DATA_W       = 8;
    localparam int BURST_LEN    = 4;
    localparam int T_RCD        = 4;
    localparam int T_CAS        = 1;
    localparam int T_CP         = 1;
    localparam int T_RAS        = 5;
    localparam int T_RP         = 3;
    localparam int REF_INTERVAL = 60;
    localparam int REF_ROWS     = 16;
    localparam int AW           = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int NROWS        = 1 << ROW_W;
    localparam int NCOLS        = 1 << COL_W;
    localparam int RUN          = 3600;
    localparam int WATCHDOG     = 20000;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        req_valid = 1'b0;
    logic                        req_ready;
    logic                        req_write = 1'b0;
    logic [ROW_W+COL_W-1:0]      req_addr = '0;
    logic [BURST_LEN*DATA_W-1:0] req_wdata = '0;
    logic                        rd_valid;
    logic [DATA_W-1:0]           rd_data;
    logic                        ref_mode = 1'b0;
    logic                        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [AW-1:0]               dram_addr;
    logic [DATA_W-1:0]           dram_dq_out;
    logic [DATA_W-1:0]           dram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS), .T_RP(T_RP),
        .REF_INTERVAL(REF_INTERVAL), .REF_ROWS(REF_ROWS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_mode(ref_mode),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    // ---------------- memory stub ----------------
    logic [DATA_W-1:0] smem [NROWS][NCOLS];
    int  lrow = 0;
    logic prev_ras = 1'b1;

    always_comb begin
        if (!dram_cas_n && dram_we_n && !dram_ras_n)
            dram_dq_in = smem[lrow][dram_addr[COL_W-1:0]];
        else
            dram_dq_in = '0;
    end

    always @(posedge clk) begin
        if (prev_ras && !dram_ras_n && dram_cas_n) lrow <= int'(dram_addr[ROW_W-1:0]);
        if (!dram_ras_n && !dram_cas_n && !dram_we_n)
            smem[lrow][dram_addr[COL_W-1:0]] <= dram_dq_out;
        prev_ras <= dram_ras_n;
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit ras, cas, we, oe, ack, rdv;
        int addr, dq, rdd;
    } vec_t;

    typedef struct {
        bit  wr;
        int  row, col;
        logic [BURST_LEN*DATA_W-1:0] wd;
    } req_t;

    vec_t q[$];
    req_t rq[$];
    logic [DATA_W-1:0] emem [NROWS][NCOLS];
    int  tcnt = 0;
    bit  pend = 0;
    int  mrow = 0;
    bit  mk_rd = 0;
    int  mk_data = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;
    int unsigned seed = 32'h1234_5678;
    int  last_row = 0, last_col = 0;

    function automatic vec_t mkv(bit ras, bit cas, bit we, bit oe, bit ack, int addr, int dq);
        vec_t v;
        v.ras = ras; v.cas = cas; v.we = we; v.oe = oe; v.ack = ack;
        v.addr = addr; v.dq = dq; v.rdv = 0; v.rdd = 0;
        return v;
    endfunction

    function automatic void push(vec_t v);
        if (mk_rd) begin v.rdv = 1; v.rdd = mk_data; mk_rd = 0; end
        q.push_back(v);
    endfunction

    function automatic int unsigned nxt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic void gen_burst(req_t r);
        int low;
        int c;
        for (int i = 0; i < T_RCD; i++) push(mkv(0, 1, !r.wr, 0, 1, r.row, 0));
        for (int b = 0; b < BURST_LEN; b++) begin
            c = (r.col + b) % NCOLS;
            for (int i = 0; i < T_CAS; i++)
                push(mkv(0, 0, !r.wr, r.wr, 1, c, int'(r.wd[b*DATA_W +: DATA_W])));
            if (r.wr) emem[r.row][c] = r.wd[b*DATA_W +: DATA_W];
            else begin mk_rd = 1; mk_data = int'(emem[r.row][c]); end
            if (b < BURST_LEN - 1)
                for (int i = 0; i < T_CP; i++) push(mkv(0, 1, !r.wr, 0, 0, 0, 0));
        end
        low = T_RCD + BURST_LEN*T_CAS + (BURST_LEN-1)*T_CP;
        for (int i = 0; i < ((T_RAS - low > 1) ? T_RAS - low : 1); i++)
            push(mkv(0, 1, !r.wr, 0, 0, 0, 0));
        for (int i = 0; i < T_RP; i++) push(mkv(1, 1, 1, 0, 0, 0, 0));
    endfunction

    function automatic void gen_ref(bit cbr);
        if (cbr) begin
            push(mkv(1, 0, 1, 0, 0, 0, 0));
            for (int i = 0; i < T_RAS; i++) push(mkv(0, 0, 1, 0, 0, 0, 0));
        end else begin
            for (int i = 0; i < T_RAS; i++) push(mkv(0, 1, 1, 0, 1, mrow, 0));
            mrow = (mrow + 1) % REF_ROWS;
        end
        for (int i = 0; i < T_RP; i++) push(mkv(1, 1, 1, 0, 0, 0, 0));
    endfunction

    function automatic req_t new_req();
        req_t r;
        int unsigned x;
        x = nxt();
        r.wr = x[0];
        if (!r.wr && x[1]) begin
            r.row = last_row; r.col = last_col;
        end else begin
            r.row = int'(x[5:2]) % NROWS;
            r.col = int'(x[9:6]) % NCOLS;
        end
        for (int b = 0; b < BURST_LEN; b++) r.wd[b*DATA_W +: DATA_W] = DATA_W'(nxt());
        if (r.wr) begin last_row = r.row; last_col = r.col; end
        return r;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, what, $time, act, exp);
        end
    endtask

    // One bench cycle: compare, drive inputs for the coming edge, advance model.
    task automatic step(int k);
        vec_t e;
        bit   idle_now;
        bit   started;
        idle_now = (q.size() == 0);
        e = idle_now ? mkv(1, 1, 1, 0, 0, 0, 0) : q[0];
        chk(dram_ras_n === e.ras, "R2 R4 R8 R9 R10 R11", "ras_n", int'(dram_ras_n), int'(e.ras));
        chk(dram_cas_n === e.cas, "R3 R10", "cas_n", int'(dram_cas_n), int'(e.cas));
        chk(dram_we_n === e.we, "R6", "we_n", int'(dram_we_n), int'(e.we));
        chk(dram_dq_oe === e.oe, "R6", "dq_oe", int'(dram_dq_oe), int'(e.oe));
        if (e.oe) chk(int'(dram_dq_out) == e.dq, "R6", "dq_out", int'(dram_dq_out), e.dq);
        if (e.ack) chk(int'(dram_addr) == e.addr, "R2 R3 R9", "addr", int'(dram_addr), e.addr);
        chk(rd_valid === e.rdv, "R5", "rd_valid", int'(rd_valid), int'(e.rdv));
        if (e.rdv) chk(int'(rd_data) == e.rdd, "R5", "rd_data", int'(rd_data), e.rdd);
        chk(req_ready === (idle_now && !pend), "R7 R8", "req_ready",
            int'(req_ready), int'(idle_now && !pend));

        // Refresh style by phase: row-only, then strobe-order, then row-only.
        ref_mode = (k >= RUN/3) && (k < 2*RUN/3);
        if (rq.size() == 0 && (k % 40) < 28 && k < RUN - 60) rq.push_back(new_req());
        req_valid = (rq.size() > 0);
        if (rq.size() > 0) begin
            req_write = rq[0].wr;
            req_addr  = {ROW_W'(rq[0].row), COL_W'(rq[0].col)};
            req_wdata = rq[0].wd;
        end

        started = 0;
        if (!idle_now) void'(q.pop_front());
        else if (pend) begin gen_ref(ref_mode); started = 1; end
        else if (req_valid) begin gen_burst(rq[0]); void'(rq.pop_front()); end
        if (tcnt == REF_INTERVAL - 1) begin
            if (pend && !started)
                chk(0, "R11", "refresh deadline", 1, 0);
            pend = 1;
        end else if (started) pend = 0;
        tcnt = (tcnt == REF_INTERVAL - 1) ? 0 : tcnt + 1;
    endtask

    initial begin
        for (int r = 0; r < NROWS; r++)
            for (int c = 0; c < NCOLS; c++) begin
                smem[r][c] = DATA_W'((r * NCOLS + c) ^ 8'hA5);
                emem[r][c] = DATA_W'((r * NCOLS + c) ^ 8'hA5);
            end
        repeat (4) @(negedge clk);
        // R1: quiet pins while reset is held.
        chk(dram_ras_n === 1'b1, "R1", "reset ras_n", int'(dram_ras_n), 1);
        chk(dram_cas_n === 1'b1, "R1", "reset cas_n", int'(dram_cas_n), 1);
        chk(dram_we_n === 1'b1, "R1", "reset we_n", int'(dram_we_n), 1);
        chk(dram_dq_oe === 1'b0, "R1", "reset dq_oe", int'(dram_dq_oe), 0);
        chk(rd_valid === 1'b0, "R1", "reset rd_valid", int'(rd_valid), 0);
        chk(req_ready === 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
        rst_n = 1'b1;
        step(0);
        for (int k = 1; k < RUN; k++) begin
            @(negedge clk);
            step(k);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R7: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule